// File: doc/BRIEF.md
# Serial Interrupt Slave Agent

This block is the peripheral-side end of a single-wire serialized interrupt bus. It runs on the bus clock and watches the shared, wired-low line for a start pulse driven by any agent. From the rising edge that ends the start pulse, it steps through a fixed train of three-clock data frames. In each frame whose request is active, it pulls the line low in the first clock and actively restores it high in the second. It releases the line in the third clock. The line is presented to the block as a sampled input. The block drives it through a separate drive-enable output and a drive-value output, and the pad and pull-up sit outside.

Requests arrive as a vector of active-low interrupt lines indexed by interrupt number, together with an active-low SMI request. An enable input chooses whether the third frame carries the SMI or interrupt 2. A polarity input inverts interrupt 8 before it is serialized. The values are frozen when the start pulse ends, so each frame reflects one coherent picture. The block also measures the width of the stop pulse that closes each cycle. A short pulse puts the bus in quiet mode, where the agent may open a cycle itself when its requests change. A longer pulse returns the bus to continuous mode, where only the host starts cycles.

Top module: `sirq_agent`

## Requirements
- R1: During reset and after it the agent leaves the line released, and the bus starts in continuous mode, so pending requests do not make the agent start a cycle.
- R2: Counting the clock in which the line first reads high after a start pulse as clock 0, frame N (1..16) has its sample clock at clock 3N-1. When the frozen value for that frame is low, the agent drives the line low (drive enable 1, drive value 0) in that clock.
- R3: In the clock after a sample clock in which it drove low, the agent drives the line high (drive enable 1, drive value 1). In the third clock of every frame it releases the line, and it never drives low in two consecutive clocks.
- R4: For a frame whose frozen value is high, the drive enable stays 0 in all three of its clocks.
- R5: Frame k for k in 2 and 4..16 carries interrupt k-1 (vector bit k-1). Frame 1 is never driven, and vector bit 0 has no effect.
- R6: Frame 3 carries the SMI request when the SMI enable input is 1 and vector bit 2 when it is 0.
- R7: When the polarity input is 1, frame 9 carries the inverse of vector bit 8; otherwise it carries bit 8 as is.
- R8: Request values are captured in the clock in which the line first reads high after the start pulse. Input changes after that clock do not alter the frames of the running cycle.
- R9: The agent serializes its frames after every start pulse, whether the host or the agent itself began it.
- R10: A stop pulse that holds the line low for at most 2 clocks selects quiet mode, and one of 3 or more clocks selects continuous mode. The new mode applies from the clock after the line returns high.
- R11: In quiet mode, while idle, when the current request picture differs from the last one transmitted, the agent drives the line low for exactly one clock to open a cycle. In continuous mode it never does so.
- R12: From the end of frame 16 until the stop pulse has finished, the agent leaves the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req_n | input | 16 | Active-low interrupt requests, bit i is interrupt i |
| smi_req_n | input | 1 | Active-low SMI request |
| smi_en | input | 1 | 1 routes the SMI onto frame 3, 0 routes interrupt 2 |
| irq8_invert | input | 1 | 1 inverts interrupt 8 before serialization |
| sirq_i | input | 1 | Sampled level of the shared line |
| sirq_oe | output | 1 | Drive enable for the shared line |
| sirq_o | output | 1 | Level driven while the drive enable is 1 |

## Verification
The bench checks the frame boundaries by checking drive enable and value at every clock offset of the train. An off-by-one counter shifts every low pulse into the recovery or turnaround clock and fails at once. It changes inputs in the middle of a cycle and restores them before the stop pulse. A design that does not freeze its requests serializes the changed value, and one that compares against live inputs rather than the transmitted picture starts a spurious cycle. It sends stop pulses of 2 and 3 clocks and then changes requests while idle. A design with the width threshold wrong either never self-starts in quiet mode or starts cycles in continuous mode. It toggles vector bit 0, bit 2 against the SMI, and bit 8 against the polarity input. A wrong slot map shows up as a low pulse in frame 1 or the wrong value in frames 3 and 9.

// File: rtl/sirq_pkg.sv
// Shared types of the serial interrupt slave agent.
// Assumes nothing beyond IEEE 1800-2017 enums.
package sirq_pkg;

    // Bus-level position of the agent within one serial cycle.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // line idle, waiting for a start pulse
        ST_START = 3'd1,  // start pulse in progress
        ST_DATA  = 3'd2,  // data frame train running
        ST_STOPW = 3'd3,  // frames done, waiting for the stop pulse
        ST_STOPL = 3'd4   // stop pulse in progress, width being counted
    } sirq_state_e;

    // Clock within a three-clock data frame.
    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_RECOV  = 2'd1,
        PH_TURN   = 2'd2
    } sirq_phase_e;

endpackage

// File: rtl/sirq_req_map.sv
// Request mapper: turns the interrupt vector, SMI and polarity controls
// into one active-low value per serial frame (bit k-1 feeds frame k).
// Assumes frame 1 is unused, SHARED_SLOT is shared between the SMI and
// its own interrupt, and INV_SLOT carries the invertible interrupt.
module sirq_req_map #(
    parameter int NUM_SLOTS   = 16,
    parameter int SHARED_SLOT = 3,
    parameter int INV_SLOT    = 9
) (
    input  logic [NUM_SLOTS-1:0] irq_req_n,
    input  logic                 smi_req_n,
    input  logic                 smi_en,
    input  logic                 irq8_invert,
    output logic [NUM_SLOTS-1:0] slot_val_n
);

    // One mapping cell per frame, the variant chosen by frame position.
    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
        if (gi == 0) begin : g_unused
            assign slot_val_n[gi] = 1'b1;
        end else if (gi == SHARED_SLOT - 1) begin : g_shared
            assign slot_val_n[gi] = smi_en ? smi_req_n : irq_req_n[gi];
        end else if (gi == INV_SLOT - 1) begin : g_invert
            assign slot_val_n[gi] = irq_req_n[gi] ^ irq8_invert;
        end else begin : g_plain
            assign slot_val_n[gi] = irq_req_n[gi];
        end
    end

endmodule

// File: rtl/sirq_frame_seq.sv
// Frame sequencer: follows the shared line through start pulse, data
// frames and stop pulse, and decodes the stop width into the bus mode.
// Assumes the line input is already synchronous to the bus clock.
module sirq_frame_seq
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS   = 16,
    parameter int STOP_W      = 4,
    parameter int QUIET_MAX_W = 2,
    localparam int SLOT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output sirq_state_e       state_q,
    output sirq_phase_e       phase_q,
    output logic [SLOT_W-1:0] slot_q,
    output logic              quiet_q,
    output logic              capture
);

    logic [STOP_W-1:0] width_q;

    // Requests are frozen in the clock where the start pulse ends.
    assign capture = (state_q == ST_START) && line_i;

    // Cycle state, frame position, stop width and bus mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_TURN;
            slot_q  <= '0;
            quiet_q <= 1'b0;
            width_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!line_i) state_q <= ST_START;
                end
                ST_START: begin
                    if (line_i) begin
                        state_q <= ST_DATA;
                        phase_q <= PH_TURN;
                        slot_q  <= '0;
                    end
                end
                ST_DATA: begin
                    case (phase_q)
                        PH_SAMPLE: phase_q <= PH_RECOV;
                        PH_RECOV:  phase_q <= PH_TURN;
                        default: begin
                            if (slot_q == SLOT_W'(NUM_SLOTS)) begin
                                state_q <= ST_STOPW;
                            end else begin
                                phase_q <= PH_SAMPLE;
                                slot_q  <= slot_q + SLOT_W'(1);
                            end
                        end
                    endcase
                end
                ST_STOPW: begin
                    if (!line_i) begin
                        state_q <= ST_STOPL;
                        width_q <= STOP_W'(1);
                    end
                end
                ST_STOPL: begin
                    if (line_i) begin
                        quiet_q <= (width_q <= STOP_W'(QUIET_MAX_W));
                        state_q <= ST_IDLE;
                    end else if (width_q != '1) begin
                        width_q <= width_q + STOP_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sirq_drive.sv
// Line driver: holds the frozen request picture and decides, each clock,
// whether to pull the line low, restore it high or leave it released.
// Assumes the sequencer's state, phase and frame index are registered.
module sirq_drive
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS + 1),
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  sirq_state_e          state_q,
    input  sirq_phase_e          phase_q,
    input  logic [SLOT_W-1:0]    slot_q,
    input  logic                 quiet_q,
    input  logic                 capture,
    input  logic [NUM_SLOTS-1:0] slot_val_n,
    output logic                 drv_oe,
    output logic                 drv_val
);

    logic [NUM_SLOTS-1:0] snap_q;
    logic                 drove_q;
    logic [SLOT_W-1:0]    slot_m1;
    logic                 cur_n;
    logic                 data_low;
    logic                 pending;

    // Frozen value of the frame currently on the bus.
    always_comb begin
        slot_m1 = slot_q - SLOT_W'(1);
        cur_n   = (slot_q == '0) ? 1'b1 : snap_q[slot_m1[IDX_W-1:0]];
    end

    assign data_low = (state_q == ST_DATA) && (phase_q == PH_SAMPLE) && !cur_n;
    assign pending  = (slot_val_n != snap_q);

    // Snapshot of the transmitted picture and the low-drive memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q  <= '1;
            drove_q <= 1'b0;
        end else begin
            if (capture) snap_q <= slot_val_n;
            drove_q <= data_low;
        end
    end

    // Line drive: sample low, recovery high, or a one-clock self start.
    always_comb begin
        drv_oe  = 1'b0;
        drv_val = 1'b1;
        if (data_low) begin
            drv_oe  = 1'b1;
            drv_val = 1'b0;
        end else if ((state_q == ST_DATA) && (phase_q == PH_RECOV) && drove_q) begin
            drv_oe  = 1'b1;
            drv_val = 1'b1;
        end else if ((state_q == ST_IDLE) && quiet_q && pending) begin
            drv_oe  = 1'b1;
            drv_val = 1'b0;
        end
    end

endmodule

// File: rtl/sirq_agent.sv
// Serial interrupt slave agent top: maps requests to frames, follows the
// bus cycle and drives the shared line through enable and value outputs.
// Assumes an external wired-low line whose level returns on sirq_i.
module sirq_agent
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS   = 16,
    parameter int SHARED_SLOT = 3,
    parameter int INV_SLOT    = 9,
    parameter int STOP_W      = 4,
    parameter int QUIET_MAX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] irq_req_n,
    input  logic                 smi_req_n,
    input  logic                 smi_en,
    input  logic                 irq8_invert,
    input  logic                 sirq_i,
    output logic                 sirq_oe,
    output logic                 sirq_o
);

    localparam int SLOT_W = $clog2(NUM_SLOTS + 1);

    logic [NUM_SLOTS-1:0] slot_val_n;
    sirq_state_e          seq_state;
    sirq_phase_e          seq_phase;
    logic [SLOT_W-1:0]    seq_slot;
    logic                 seq_quiet;
    logic                 seq_capture;

    sirq_req_map #(
        .NUM_SLOTS  (NUM_SLOTS),
        .SHARED_SLOT(SHARED_SLOT),
        .INV_SLOT   (INV_SLOT)
    ) u_map (
        .irq_req_n  (irq_req_n),
        .smi_req_n  (smi_req_n),
        .smi_en     (smi_en),
        .irq8_invert(irq8_invert),
        .slot_val_n (slot_val_n)
    );

    sirq_frame_seq #(
        .NUM_SLOTS  (NUM_SLOTS),
        .STOP_W     (STOP_W),
        .QUIET_MAX_W(QUIET_MAX_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (sirq_i),
        .state_q(seq_state),
        .phase_q(seq_phase),
        .slot_q (seq_slot),
        .quiet_q(seq_quiet),
        .capture(seq_capture)
    );

    sirq_drive #(
        .NUM_SLOTS(NUM_SLOTS)
    ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (seq_state),
        .phase_q   (seq_phase),
        .slot_q    (seq_slot),
        .quiet_q   (seq_quiet),
        .capture   (seq_capture),
        .slot_val_n(slot_val_n),
        .drv_oe    (sirq_oe),
        .drv_val   (sirq_o)
    );

endmodule

// File: rtl/sirq_agent_chk.sv
// Protocol checker for the serial interrupt slave agent, bound to the top.
// Assumes it sees the line drive outputs and the sequencer state.
module sirq_agent_chk
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drv_oe,
    input logic              drv_val,
    input sirq_state_e       st,
    input sirq_phase_e       ph,
    input logic [SLOT_W-1:0] slot
);

    assert_reset_released_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !drv_oe);

    assert_low_in_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && drv_oe && !drv_val) |-> (ph == PH_SAMPLE));

    assert_low_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_oe && !drv_val) |=> !(drv_oe && !drv_val));

    assert_high_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_oe && drv_val) |-> $past(drv_oe && !drv_val));

    assert_release_after_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_oe && drv_val) |=> !drv_oe);

    assert_frame1_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && ph == PH_SAMPLE && slot == SLOT_W'(1)) |-> !drv_oe);

    assert_stop_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOPW || st == ST_STOPL) |-> !drv_oe);

endmodule

bind sirq_agent sirq_agent_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .drv_oe (sirq_oe),
    .drv_val(sirq_o),
    .st     (seq_state),
    .ph     (seq_phase),
    .slot   (seq_slot)
);

// File: tb/tb_sirq_agent.sv
// Bench for the serial interrupt slave agent: a host model drives start and
// stop pulses, and a behavioural reference predicts every clock's drive.
module tb_sirq_agent;

    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_n = '1;
    logic          smi_n = 1'b1;
    logic          smi_en = 1'b0;
    logic          inv = 1'b0;
    logic          host_low = 1'b0;
    logic          sirq_i;
    logic          sirq_oe;
    logic          sirq_o;

    logic [NS-1:0] nx_irq = '1;
    logic          nx_smi = 1'b1;
    logic          nx_en = 1'b0;
    logic          nx_inv = 1'b0;

    logic [NS-1:0] last_sent = '1;
    bit            quiet_m = 1'b0;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;

    always #4 clk = ~clk;

    // Wired-low line: any low driver wins.
    assign sirq_i = !((sirq_oe && !sirq_o) || host_low);

    sirq_agent dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req_n  (irq_n),
        .smi_req_n  (smi_n),
        .smi_en     (smi_en),
        .irq8_invert(inv),
        .sirq_i     (sirq_i),
        .sirq_oe    (sirq_oe),
        .sirq_o     (sirq_o)
    );

    // Frame picture the requirements predict for the current inputs.
    function automatic logic [NS-1:0] ref_pic();
        logic [NS-1:0] v;
        v    = irq_n;
        v[0] = 1'b1;
        v[2] = smi_en ? smi_n : irq_n[2];
        v[8] = irq_n[8] ^ inv;
        return v;
    endfunction

    task automatic chk(bit e_oe, bit e_val, string tag, string what);
        n_chk++;
        if (sirq_oe !== e_oe || (e_oe && sirq_o !== e_val)) begin
            n_bad++;
            $display("FAIL %s %s: oe=%b val=%b expected oe=%b val=%b",
                     tag, what, sirq_oe, sirq_o, e_oe, e_val);
        end
    endtask

    // Advance one clock period: apply host level and inputs at the falling edge.
    task automatic tick(bit h);
        @(negedge clk);
        host_low = h;
        irq_n    = nx_irq;
        smi_n    = nx_smi;
        smi_en   = nx_en;
        inv      = nx_inv;
        #1;
    endtask

    // One full bus cycle: start pulse, frame train, gap, stop pulse.
    task automatic bus_cycle(int start_w, bit agent_first, int stop_w, int gap, bit mid);
        logic [NS-1:0] sent;
        logic [NS-1:0] keep;
        bit e_self;
        tick(!agent_first);
        e_self = quiet_m && (ref_pic() != last_sent);
        chk(e_self, 1'b0, agent_first ? "R11" : "R9", "start lead");
        for (int i = 1; i < start_w; i++) begin
            tick(1'b1);
            chk(1'b0, 1'b1, agent_first ? "R11" : "R9", "start hold");
        end
        tick(1'b0);
        chk(1'b0, 1'b1, "R9", "start rise");
        sent = ref_pic();
        keep = nx_irq;
        for (int k = 1; k <= 3 * NS + 1; k++) begin
            int n;
            int ph;
            bit e_oe;
            bit e_val;
            string tag;
            if (mid && k == 20) nx_irq = keep ^ 16'h0FF0;
            if (mid && k == 40) nx_irq = keep;
            tick(1'b0);
            n = (k + 1) / 3;
            ph = (k + 1) % 3;
            e_oe = 1'b0;
            e_val = 1'b1;
            tag = "R4";
            if (n >= 1 && n <= NS && !sent[n-1]) begin
                if (ph == 0) begin e_oe = 1'b1; e_val = 1'b0; tag = "R2"; end
                else if (ph == 1) begin e_oe = 1'b1; e_val = 1'b1; tag = "R3"; end
                else tag = "R3";
            end
            if (n == 1) tag = "R5";
            if (n == 3) tag = "R6";
            if (n == 9) tag = "R7";
            if (mid) tag = "R8";
            chk(e_oe, e_val, tag, $sformatf("frame %0d clock %0d", n, k));
        end
        last_sent = sent;
        for (int i = 0; i < gap; i++) begin
            tick(1'b0);
            chk(1'b0, 1'b1, "R12", "gap");
        end
        for (int i = 0; i < stop_w; i++) begin
            tick(1'b1);
            chk(1'b0, 1'b1, "R12", "stop low");
        end
        tick(1'b0);
        chk(1'b0, 1'b1, "R12", "stop rise");
        quiet_m = (stop_w <= 2);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end

    initial begin
        // R1: reset with every request pending.
        nx_irq = '0;
        for (int i = 0; i < 3; i++) begin
            tick(1'b0);
            chk(1'b0, 1'b1, "R1", "in reset");
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(1'b0);
            chk(1'b0, 1'b1, "R1", "idle after reset");
        end
        // R2 R3 R4 R5: plain mapping, host start of 4 clocks.
        nx_irq = 16'hA5C3;
        bus_cycle(4, 1'b0, 3, 0, 1'b0);
        // R5 R6 R7: bit 0 low, SMI on frame 3, interrupt 8 inverted.
        nx_irq = 16'h5D14;
        nx_smi = 1'b0;
        nx_en  = 1'b1;
        nx_inv = 1'b1;
        bus_cycle(8, 1'b0, 3, 1, 1'b0);
        // R6 R8 R10: SMI idle masks bit 2, mid-cycle changes, short stop.
        nx_irq = 16'h02FA;
        nx_smi = 1'b1;
        nx_inv = 1'b0;
        bus_cycle(6, 1'b0, 2, 0, 1'b1);
        // R11: quiet mode, nothing new to send.
        for (int i = 0; i < 3; i++) begin
            tick(1'b0);
            chk(1'b0, 1'b1, "R11", "quiet no change");
        end
        // R9 R11: a change makes the agent open the cycle itself.
        nx_irq = nx_irq ^ 16'h0020;
        bus_cycle(4, 1'b1, 3, 0, 1'b0);
        // R10: continuous again, a change must not start a cycle.
        nx_irq = nx_irq ^ 16'h1000;
        for (int i = 0; i < 3; i++) begin
            tick(1'b0);
            chk(1'b0, 1'b1, "R10", "continuous no self start");
        end
        bus_cycle(5, 1'b0, 3, 0, 1'b0);
        report();
    end

endmodule